// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Resolver

This block finishes the acknowledge bus cycle that a processor runs when it accepts one of seven prioritized interrupt levels, and it reports the 8-bit exception vector number for that level. The processor raises an acknowledge strobe together with the level being served. The block then waits for one of three ways to end the cycle. The first is a data-size acknowledge, where the vector is taken from the low byte of the data bus. The second is an autovector input on a shared pin. The third is a per-level enable register that forces autovectoring internally. In the last two cases the bus byte is discarded and the vector becomes the level plus 24, so levels 1 to 7 give vectors 25 to 31.

The shared pin has two roles. A pin-assignment bit either makes it the autovector input or turns it into the active-low acknowledge output for level 5. Separate active-low acknowledge strobes are also produced for every level. All results are registered, so each output appears one clock after the inputs that cause it are sampled.

Top module: `iack_vector_resolver`

## Requirements
- R1: A sample with the acknowledge strobe high and level 0 is ignored. It produces no vector-valid pulse, asserts no acknowledge strobe and leaves the vector unchanged.
- R2: When no autovector condition applies and any bit of the data-size acknowledge (active low, 2 bits) is low, the vector becomes bits 7:0 of the data bus.
- R3: With the pin in autovector mode (assignment bit 0), a low level on the pin ends the cycle with vector 24 + level. This takes priority over a data-size acknowledge in the same sample, and the bus byte is then discarded.
- R4: Bit k of the autovector enable register forces autovector termination for level k+1, giving vector 24 + level with no acknowledge input. A bit set for any other level has no effect on the cycle being served.
- R5: Outside an acknowledge cycle, the autovector pin, the data-size acknowledge and the enable register change neither the vector nor the valid output.
- R6: With the assignment bit at 1, the pin is driven (output enable 1). It goes low only in the clock after a level-5 acknowledge sample, and a low input on it never ends a cycle.
- R7: With the assignment bit at 0, the pin output enable is 0, and this includes cycles ended by the enable register.
- R8: Vector-valid is high for exactly one clock per acknowledge cycle, in the clock after the terminating sample. The vector keeps its value until the next termination.
- R9: The acknowledge strobe for level k (bit k-1 of the strobe bus, active low) is low in every clock after a sample of level k with the acknowledge strobe high. All strobe bits are high otherwise.
- R10: During reset the vector is 0, vector-valid is 0, all acknowledge strobes are high and the pin reads high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_cycle | input | 1 | High while an interrupt acknowledge cycle runs |
| ack_level | input | 3 | Interrupt level being acknowledged |
| bus_data | input | 16 | External data bus; low byte carries a supplied vector |
| dsack_n | input | 2 | Data-size acknowledge, active low |
| avec_pin_n_i | input | 1 | Level seen on the shared pin |
| pin_is_ack5 | input | 1 | 1: shared pin is the level-5 acknowledge output; 0: autovector input |
| auto_en | input | 7 | Per-level forced autovector enable, bit k for level k+1 |
| vector | output | 8 | Resolved exception vector number |
| vector_valid | output | 1 | One-clock pulse when a cycle terminates |
| iack_n | output | 7 | Per-level acknowledge strobes, active low |
| avec_pin_n_o | output | 1 | Value driven on the shared pin |
| avec_pin_oe | output | 1 | Output enable of the shared pin |

## Verification
Each result is due one clock edge after the sample that causes it. Vector-valid, the vector, the acknowledge strobes and the shared pin level all update on the edge that first sees the acknowledge strobe with its termination inputs. The pin output enable follows the assignment bit with no delay. The bench changes inputs on the falling edge and reads outputs on the next falling edge, half a period after the edge that moved them. A second falling edge with the cycle still held confirms that the valid pulse has ended and the vector is unchanged. A third falling edge after the strobe drops confirms that the acknowledge strobes have been released.

// File: rtl/iack_pkg.sv
package iack_pkg;
   // Way in which the current acknowledge sample ends the cycle
   typedef enum logic [1:0] {
      TERM_NONE = 2'd0,
      TERM_BUS  = 2'd1,
      TERM_AUTO = 2'd2
   } term_kind_e;
endpackage

// File: rtl/iack_level_decode.sv
module iack_level_decode #(
   parameter int LEVEL_W    = 3,
   parameter int NUM_LEVELS = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ack_cycle,
   input  logic [LEVEL_W-1:0]    ack_level,
   output logic                  cycle_live,
   output logic [NUM_LEVELS-1:0] strobe_q
);
   // level 0 never opens a cycle
   assign cycle_live = ack_cycle && (ack_level != '0);

   for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_lvl
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) strobe_q[k] <= 1'b0;
         else        strobe_q[k] <= cycle_live && (ack_level == LEVEL_W'(k + 1));
      end
   end
endmodule

// File: rtl/iack_term_detect.sv
module iack_term_detect
   import iack_pkg::*;
#(
   parameter int LEVEL_W    = 3,
   parameter int NUM_LEVELS = 7,
   parameter int DSACK_W    = 2
) (
   input  logic                  cycle_live,
   input  logic [LEVEL_W-1:0]    ack_level,
   input  logic [DSACK_W-1:0]    dsack_n,
   input  logic                  avec_pin_n_i,
   input  logic                  pin_is_ack5,
   input  logic [NUM_LEVELS-1:0] auto_en,
   output term_kind_e            kind
);
   logic forced_hit;
   logic pin_hit;
   logic bus_hit;

   always_comb begin
      forced_hit = 1'b0;
      for (int k = 0; k < NUM_LEVELS; k++) begin
         if (ack_level == LEVEL_W'(k + 1) && auto_en[k]) forced_hit = 1'b1;
      end
   end

   // pin counts as an autovector input only in its input role
   assign pin_hit = !pin_is_ack5 && !avec_pin_n_i;
   assign bus_hit = !(&dsack_n);

   always_comb begin
      if (!cycle_live)                kind = TERM_NONE;
      else if (forced_hit || pin_hit) kind = TERM_AUTO;
      else if (bus_hit)               kind = TERM_BUS;
      else                            kind = TERM_NONE;
   end
endmodule

// File: rtl/iack_vector_reg.sv
module iack_vector_reg
   import iack_pkg::*;
#(
   parameter int LEVEL_W   = 3,
   parameter int VEC_W     = 8,
   parameter int DATA_W    = 16,
   parameter int AVEC_BASE = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ack_cycle,
   input  term_kind_e         kind,
   input  logic [LEVEL_W-1:0] ack_level,
   input  logic [DATA_W-1:0]  bus_data,
   output logic [VEC_W-1:0]   vector,
   output logic               vector_valid
);
   localparam logic [VEC_W-1:0] BASE = VEC_W'(AVEC_BASE);

   logic done_q;
   logic fire;

   assign fire = (kind != TERM_NONE) && !done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q       <= 1'b0;
         vector_valid <= 1'b0;
         vector       <= '0;
      end else begin
         vector_valid <= fire;
         if (!ack_cycle) done_q <= 1'b0;
         else if (fire)  done_q <= 1'b1;
         if (fire) begin
            if (kind == TERM_AUTO) vector <= BASE + VEC_W'(ack_level);
            else                   vector <= bus_data[VEC_W-1:0];
         end
      end
   end
endmodule

// File: rtl/iack_vector_resolver.sv
module iack_vector_resolver
   import iack_pkg::*;
#(
   parameter int LEVEL_W      = 3,
   parameter int NUM_LEVELS   = 7,
   parameter int VEC_W        = 8,
   parameter int DATA_W       = 16,
   parameter int DSACK_W      = 2,
   parameter int AVEC_BASE    = 24,
   parameter int SHARED_LEVEL = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ack_cycle,
   input  logic [LEVEL_W-1:0]    ack_level,
   input  logic [DATA_W-1:0]     bus_data,
   input  logic [DSACK_W-1:0]    dsack_n,
   input  logic                  avec_pin_n_i,
   input  logic                  pin_is_ack5,
   input  logic [NUM_LEVELS-1:0] auto_en,
   output logic [VEC_W-1:0]      vector,
   output logic                  vector_valid,
   output logic [NUM_LEVELS-1:0] iack_n,
   output logic                  avec_pin_n_o,
   output logic                  avec_pin_oe
);
   localparam int MAX_LEVEL = (1 << LEVEL_W) - 1;
   localparam int TOP_VEC   = AVEC_BASE + NUM_LEVELS;

   if (NUM_LEVELS > MAX_LEVEL) begin : g_bad_levels
      $error("NUM_LEVELS exceeds what LEVEL_W can encode");
   end
   if (TOP_VEC >= (1 << VEC_W)) begin : g_bad_base
      $error("autovector range does not fit VEC_W");
   end
   if (SHARED_LEVEL < 1 || SHARED_LEVEL > NUM_LEVELS) begin : g_bad_shared
      $error("SHARED_LEVEL outside 1..NUM_LEVELS");
   end
   if (DATA_W < VEC_W) begin : g_bad_data
      $error("DATA_W narrower than VEC_W");
   end

   logic                  cycle_live;
   logic [NUM_LEVELS-1:0] strobe_q;
   term_kind_e            kind;

   iack_level_decode #(
      .LEVEL_W   (LEVEL_W),
      .NUM_LEVELS(NUM_LEVELS)
   ) u_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .ack_cycle (ack_cycle),
      .ack_level (ack_level),
      .cycle_live(cycle_live),
      .strobe_q  (strobe_q)
   );

   iack_term_detect #(
      .LEVEL_W   (LEVEL_W),
      .NUM_LEVELS(NUM_LEVELS),
      .DSACK_W   (DSACK_W)
   ) u_term (
      .cycle_live  (cycle_live),
      .ack_level   (ack_level),
      .dsack_n     (dsack_n),
      .avec_pin_n_i(avec_pin_n_i),
      .pin_is_ack5 (pin_is_ack5),
      .auto_en     (auto_en),
      .kind        (kind)
   );

   iack_vector_reg #(
      .LEVEL_W  (LEVEL_W),
      .VEC_W    (VEC_W),
      .DATA_W   (DATA_W),
      .AVEC_BASE(AVEC_BASE)
   ) u_vec (
      .clk         (clk),
      .rst_n       (rst_n),
      .ack_cycle   (ack_cycle),
      .kind        (kind),
      .ack_level   (ack_level),
      .bus_data    (bus_data),
      .vector      (vector),
      .vector_valid(vector_valid)
   );

   assign iack_n       = ~strobe_q;
   // pin is driven only in its acknowledge-output role
   assign avec_pin_oe  = pin_is_ack5;
   assign avec_pin_n_o = ~(pin_is_ack5 && strobe_q[SHARED_LEVEL-1]);
endmodule

// File: rtl/iack_resolver_checker.sv
module iack_resolver_checker #(
   parameter int LEVEL_W      = 3,
   parameter int NUM_LEVELS   = 7,
   parameter int VEC_W        = 8,
   parameter int DATA_W       = 16,
   parameter int DSACK_W      = 2,
   parameter int AVEC_BASE    = 24,
   parameter int SHARED_LEVEL = 5
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  ack_cycle,
   input logic [LEVEL_W-1:0]    ack_level,
   input logic [DATA_W-1:0]     bus_data,
   input logic [DSACK_W-1:0]    dsack_n,
   input logic                  avec_pin_n_i,
   input logic                  pin_is_ack5,
   input logic [NUM_LEVELS-1:0] auto_en,
   input logic [VEC_W-1:0]      vector,
   input logic                  vector_valid,
   input logic [NUM_LEVELS-1:0] iack_n,
   input logic                  avec_pin_n_o,
   input logic                  avec_pin_oe
);
   logic auto_hit;

   always_comb begin
      auto_hit = ack_cycle && !pin_is_ack5 && !avec_pin_n_i && (ack_level != '0);
      for (int k = 0; k < NUM_LEVELS; k++) begin
         if (ack_cycle && ack_level == LEVEL_W'(k + 1) && auto_en[k]) auto_hit = 1'b1;
      end
   end

   a_r1_level0_silent: assert property (@(posedge clk) disable iff (!rst_n)
      vector_valid |-> ($past(ack_cycle) && $past(ack_level) != '0));

   a_r2_bus_vector: assert property (@(posedge clk) disable iff (!rst_n)
      (vector_valid && !$past(auto_hit)) |-> (vector == $past(bus_data[VEC_W-1:0])));

   a_r3_auto_vector: assert property (@(posedge clk) disable iff (!rst_n)
      (vector_valid && $past(auto_hit)) |-> (vector == VEC_W'(AVEC_BASE) + VEC_W'($past(ack_level))));

   a_r6_pin_level5_only: assert property (@(posedge clk) disable iff (!rst_n)
      (avec_pin_oe && !avec_pin_n_o) |-> ($past(ack_cycle) && $past(ack_level) == LEVEL_W'(SHARED_LEVEL)));

   a_r7_pin_released: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_is_ack5 |-> !avec_pin_oe);

   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      vector_valid |=> !vector_valid);

   a_r8_vector_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !vector_valid |-> $stable(vector));

   a_r9_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~iack_n));
endmodule

bind iack_vector_resolver iack_resolver_checker #(
   .LEVEL_W     (LEVEL_W),
   .NUM_LEVELS  (NUM_LEVELS),
   .VEC_W       (VEC_W),
   .DATA_W      (DATA_W),
   .DSACK_W     (DSACK_W),
   .AVEC_BASE   (AVEC_BASE),
   .SHARED_LEVEL(SHARED_LEVEL)
) u_chk (.*);

// File: tb/iack_vector_resolver_bench.sv
module iack_vector_resolver_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        ack_cycle;
   logic [2:0]  ack_level;
   logic [15:0] bus_data;
   logic [1:0]  dsack_n;
   logic        avec_pin_n_i;
   logic        pin_is_ack5;
   logic [6:0]  auto_en;
   logic [7:0]  vector;
   logic        vector_valid;
   logic [6:0]  iack_n;
   logic        avec_pin_n_o;
   logic        avec_pin_oe;

   int checks   = 0;
   int failures = 0;
   logic [7:0] exp_vec = 8'd0;

   always #4 clk = ~clk;

   iack_vector_resolver u_iack_vector_resolver (
      .clk(clk), .rst_n(rst_n), .ack_cycle(ack_cycle), .ack_level(ack_level),
      .bus_data(bus_data), .dsack_n(dsack_n), .avec_pin_n_i(avec_pin_n_i),
      .pin_is_ack5(pin_is_ack5), .auto_en(auto_en), .vector(vector),
      .vector_valid(vector_valid), .iack_n(iack_n),
      .avec_pin_n_o(avec_pin_n_o), .avec_pin_oe(avec_pin_oe)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      ack_cycle = 1'b0; ack_level = 3'd0; bus_data = 16'h0;
      dsack_n = 2'b11; avec_pin_n_i = 1'b1; auto_en = 7'h0;
   endtask

   // one acknowledge cycle; tag names the requirement under test
   task automatic do_ack(input logic [2:0] lvl, input logic [15:0] data,
                         input logic [1:0] ds, input logic pin, input logic mode,
                         input logic [6:0] en, input string tag);
      bit         autov;
      bit         term;
      logic [6:0] exp_iack;
      @(negedge clk);
      ack_cycle = 1'b1; ack_level = lvl; bus_data = data; dsack_n = ds;
      avec_pin_n_i = pin; pin_is_ack5 = mode; auto_en = en;
      autov    = (lvl != 0) && (en[lvl - 3'd1] || (!mode && !pin));
      term     = (lvl != 0) && (autov || ds != 2'b11);
      exp_iack = (lvl == 0) ? 7'h7f : ~(7'h1 << (lvl - 3'd1));
      if (term) exp_vec = autov ? 8'd24 + 8'(lvl) : data[7:0];
      @(negedge clk);
      check(vector_valid == term, {tag, " valid"}, 32'(vector_valid), 32'(term));
      check(vector == exp_vec, {tag, " vector"}, 32'(vector), 32'(exp_vec));
      check(iack_n == exp_iack, "R9 strobe", 32'(iack_n), 32'(exp_iack));
      check(avec_pin_oe == mode, "R7 pin enable", 32'(avec_pin_oe), 32'(mode));
      check(avec_pin_n_o == !(mode && lvl == 3'd5), "R6 pin level",
            32'(avec_pin_n_o), 32'(!(mode && lvl == 3'd5)));
      @(negedge clk);
      check(vector_valid == 1'b0, "R8 single pulse", 32'(vector_valid), 32'd0);
      check(vector == exp_vec, "R8 vector hold", 32'(vector), 32'(exp_vec));
      ack_cycle = 1'b0; dsack_n = 2'b11; avec_pin_n_i = 1'b1;
      @(negedge clk);
      check(iack_n == 7'h7f, "R9 strobe release", 32'(iack_n), 32'h7f);
      check(vector_valid == 1'b0, "R8 no pulse after", 32'(vector_valid), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst_n = 1'b0; pin_is_ack5 = 1'b0;
      idle_inputs();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10 reset state
      check(vector == 8'd0, "R10 vector", 32'(vector), 32'd0);
      check(vector_valid == 1'b0, "R10 valid", 32'(vector_valid), 32'd0);
      check(iack_n == 7'h7f, "R10 strobes", 32'(iack_n), 32'h7f);
      check(avec_pin_n_o == 1'b1, "R10 pin", 32'(avec_pin_n_o), 32'd1);
      rst_n = 1'b1;

      for (int lv = 1; lv <= 7; lv++) begin
         for (int p = 0; p < 7; p++) begin
            logic [15:0] d;
            logic [6:0]  own;
            d   = {8'hA5 ^ 8'(p), 8'h40 + 8'(lv * 8 + p)};
            own = 7'h1 << (lv - 1);
            case (p)
               0: do_ack(3'(lv), d, 2'b10, 1'b1, 1'b0, 7'h00, "R2 bus vector");
               1: do_ack(3'(lv), d, 2'b11, 1'b0, 1'b0, 7'h00, "R3 pin autovector");
               2: do_ack(3'(lv), d, 2'b00, 1'b0, 1'b0, 7'h00, "R3 autovector priority");
               3: do_ack(3'(lv), d, 2'b11, 1'b1, 1'b0, own, "R4 forced autovector");
               4: do_ack(3'(lv), d, 2'b11, 1'b0, 1'b1, 7'h00, "R6 pin low ignored");
               5: do_ack(3'(lv), d, 2'b01, 1'b0, 1'b1, 7'h00, "R6 bus in ack mode");
               default: do_ack(3'(lv), d, 2'b11, 1'b1, 1'b0, ~own, "R4 other levels");
            endcase
         end
      end

      // R1 level 0 with every termination source active
      do_ack(3'd0, 16'h00C3, 2'b00, 1'b0, 1'b0, 7'h7f, "R1 level zero");
      do_ack(3'd0, 16'h00C3, 2'b10, 1'b1, 1'b1, 7'h7f, "R1 level zero ack mode");

      // R5 termination inputs outside an acknowledge cycle
      @(negedge clk);
      pin_is_ack5 = 1'b0; ack_cycle = 1'b0; ack_level = 3'd3; dsack_n = 2'b00;
      avec_pin_n_i = 1'b0; auto_en = 7'h7f; bus_data = 16'h0077;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(vector_valid == 1'b0, "R5 valid idle", 32'(vector_valid), 32'd0);
         check(vector == exp_vec, "R5 vector idle", 32'(vector), 32'(exp_vec));
         check(iack_n == 7'h7f, "R5 strobes idle", 32'(iack_n), 32'h7f);
      end
      idle_inputs();
      @(negedge clk);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule